// File: doc/BRIEF.md
# Undefined-Opcode No-Op Sequencer

This block is a cycle-level model of the instruction sequencing in a small 8-bit processor core. It covers only two things: how the core steps through opcodes that have no defined function, and where it may accept an interrupt. Every opcode fetch is marked by a sync cycle. Late in that cycle the byte on the data bus is classified. The block then runs the right number of bus cycles for that opcode and raises a program-counter increment strobe once for each byte the instruction occupies.

Undefined opcodes become no-ops, each with a fixed byte length and cycle count. Opcodes in the two single-cycle columns never leave the fetch phase: the cycle after them is another fetch. Because of this they never reach a point where an interrupt can be taken. A run of them therefore fuses with the next ordinary instruction into one unit that cannot be interrupted. Defined opcodes are not executed. Each one stands in as a one-byte, two-cycle placeholder.

Interrupts are considered at the last cycle of any instruction longer than one cycle. The maskable request is a level that the mask input can block. The non-maskable request is latched on its rising edge, ignores the mask and wins when both are pending. An accepted interrupt takes the place of the next fetch with a one-cycle entry indication.

Top module: `nop_seq_core`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the block is in an opcode fetch: sync is high, busy and interrupt-accept are low. Any latched non-maskable request is cleared.
- R2: An opcode whose low nibble is 0x3 or 0xB takes one cycle and one increment. The cycle right after it is another sync cycle.
- R3: Opcodes 0x02, 0x22, 0x42, 0x62, 0x82, 0xC2 and 0xE2 take 2 cycles, with an increment in both.
- R4: Opcode 0x44 takes 3 cycles, with increments in the first 2.
- R5: Opcodes 0x54, 0xD4 and 0xF4 take 4 cycles, with increments in the first 2.
- R6: Opcode 0x5C takes 8 cycles, and opcodes 0xDC and 0xFC take 4 cycles. Both kinds have increments in the first 3 cycles.
- R7: Every other opcode, including 0xEA, takes 2 cycles with a single increment, in the fetch cycle.
- R8: In every cycle exactly one of sync, busy and interrupt-accept is high. The increment is high in the fetch cycle and in the operand cycles that directly follow it, and low in all other cycles.
- R9: A request pending in the last cycle of a multi-cycle instruction gives one cycle with interrupt-accept high and no increment, in place of the next fetch. A sync cycle follows it. Interrupt-accept never comes directly after a sync cycle.
- R10: After a run of single-cycle no-ops, a pending request is accepted only once the next multi-cycle instruction has completed.
- R11: The maskable request is ignored in any last cycle where the mask input is high.
- R12: A rising edge on the non-maskable input is latched. It is honoured regardless of the mask, takes priority over the maskable request, is flagged on the ack-source output, and is cleared by its acceptance. A level held high causes only one acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_i | input | 8 | Data bus byte, sampled as the opcode at the end of a sync cycle |
| irq_i | input | 1 | Maskable interrupt request, active-high level |
| irq_mask_i | input | 1 | Mask flag; when high, irq_i is ignored |
| nmi_i | input | 1 | Non-maskable request, latched on its rising edge |
| sync_o | output | 1 | High in opcode fetch cycles |
| pc_inc_o | output | 1 | Program counter advances by one in this cycle |
| busy_o | output | 1 | High in cycles after the fetch of a multi-cycle instruction |
| irq_ack_o | output | 1 | Interrupt entry cycle, in place of a fetch |
| ack_nmi_o | output | 1 | With irq_ack_o, the accepted request is the non-maskable one |

## Verification
A cycle counter that is off by one moves every later sync pulse. The first wrong cycle therefore shows at the ports within one instruction, and the whole following stream is misaligned. An operand counter that runs wrong shows as a missing or extra increment strobe inside that same instruction. A wrong fusion decision shows as an interrupt-accept directly after a single-cycle no-op, or as a fetch cycle where an accept was due. A stale non-maskable latch shows as a second accept on the next completed instruction.

// File: rtl/nop_seq_pkg.sv
package nop_seq_pkg;
    localparam int CYC_W = 4;   // wide enough for the longest (8-cycle) no-op
    localparam int LEN_W = 2;   // instruction length in bytes, 1..3

    typedef enum logic [1:0] {
        PH_FETCH = 2'd0,
        PH_EXEC  = 2'd1,
        PH_ACK   = 2'd2
    } phase_e;

    typedef struct packed {
        logic [CYC_W-1:0] cycles;
        logic [LEN_W-1:0] bytes;
        logic             single;
    } op_shape_t;
endpackage

// File: rtl/nop_seq_decode.sv
module nop_seq_decode
    import nop_seq_pkg::*;
(
    input  logic [7:0] op_i,
    output op_shape_t  shape_o
);
    always_comb begin
        shape_o.cycles = CYC_W'(2);
        shape_o.bytes  = LEN_W'(1);
        unique casez (op_i)
            8'b????_0011, 8'b????_1011: begin
                shape_o.cycles = CYC_W'(1);
                shape_o.bytes  = LEN_W'(1);
            end
            8'h02, 8'h22, 8'h42, 8'h62, 8'h82, 8'hC2, 8'hE2: begin
                shape_o.cycles = CYC_W'(2);
                shape_o.bytes  = LEN_W'(2);
            end
            8'h44: begin
                shape_o.cycles = CYC_W'(3);
                shape_o.bytes  = LEN_W'(2);
            end
            8'h54, 8'hD4, 8'hF4: begin
                shape_o.cycles = CYC_W'(4);
                shape_o.bytes  = LEN_W'(2);
            end
            8'h5C: begin
                shape_o.cycles = CYC_W'(8);
                shape_o.bytes  = LEN_W'(3);
            end
            8'hDC, 8'hFC: begin
                shape_o.cycles = CYC_W'(4);
                shape_o.bytes  = LEN_W'(3);
            end
            default: begin
                shape_o.cycles = CYC_W'(2);
                shape_o.bytes  = LEN_W'(1);
            end
        endcase
        shape_o.single = (shape_o.cycles == CYC_W'(1));
    end
endmodule

// File: rtl/nop_seq_irq.sv
module nop_seq_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_i,
    input  logic irq_mask_i,
    input  logic nmi_i,
    input  logic nmi_clr_i,
    output logic pend_o,
    output logic pend_nmi_o
);
    typedef struct packed {
        logic nmi_lat;
        logic nmi_prev;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (nmi_clr_i)
            st_d.nmi_lat = 1'b0;
        if (nmi_i && !st_q.nmi_prev)
            st_d.nmi_lat = 1'b1;
        st_d.nmi_prev = nmi_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_nmi_o = st_q.nmi_lat;
    assign pend_o     = st_q.nmi_lat || (irq_i && !irq_mask_i);

    // R12: an acceptance with no new edge leaves nothing latched
    assert_nmi_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_clr_i && !(nmi_i && !st_q.nmi_prev)) |=> !pend_nmi_o);
endmodule

// File: rtl/nop_seq_core.sv
module nop_seq_core
    import nop_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] data_i,
    input  logic       irq_i,
    input  logic       irq_mask_i,
    input  logic       nmi_i,
    output logic       sync_o,
    output logic       pc_inc_o,
    output logic       busy_o,
    output logic       irq_ack_o,
    output logic       ack_nmi_o
);
    typedef struct packed {
        phase_e           phase;
        logic [CYC_W-1:0] cyc_left;  // remaining execute cycles, including current
        logic [LEN_W-1:0] opr_left;  // operand bytes still to be stepped over
        logic             sel_nmi;
    } seq_st_t;

    seq_st_t   st_d, st_q;
    op_shape_t shape;
    logic      pend, pend_nmi, nmi_clr;

    nop_seq_decode u_decode (
        .op_i    (data_i),
        .shape_o (shape)
    );

    assign nmi_clr = (st_q.phase == PH_ACK) && st_q.sel_nmi;

    nop_seq_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_i      (irq_i),
        .irq_mask_i (irq_mask_i),
        .nmi_i      (nmi_i),
        .nmi_clr_i  (nmi_clr),
        .pend_o     (pend),
        .pend_nmi_o (pend_nmi)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_FETCH: begin
                // single-cycle no-ops never leave the fetch phase
                if (!shape.single) begin
                    st_d.phase    = PH_EXEC;
                    st_d.cyc_left = shape.cycles - CYC_W'(1);
                    st_d.opr_left = shape.bytes - LEN_W'(1);
                end
            end
            PH_EXEC: begin
                if (st_q.opr_left != '0)
                    st_d.opr_left = st_q.opr_left - LEN_W'(1);
                if (st_q.cyc_left == CYC_W'(1)) begin
                    st_d.cyc_left = '0;
                    if (pend) begin
                        st_d.phase   = PH_ACK;
                        st_d.sel_nmi = pend_nmi;
                    end else begin
                        st_d.phase = PH_FETCH;
                    end
                end else begin
                    st_d.cyc_left = st_q.cyc_left - CYC_W'(1);
                end
            end
            PH_ACK: begin
                st_d.phase   = PH_FETCH;
                st_d.sel_nmi = 1'b0;
            end
            default: st_d.phase = PH_FETCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase    <= PH_FETCH;
            st_q.cyc_left <= '0;
            st_q.opr_left <= '0;
            st_q.sel_nmi  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o    = (st_q.phase == PH_FETCH);
    assign busy_o    = (st_q.phase == PH_EXEC);
    assign irq_ack_o = (st_q.phase == PH_ACK);
    assign ack_nmi_o = irq_ack_o && st_q.sel_nmi;
    assign pc_inc_o  = sync_o || (busy_o && (st_q.opr_left != '0));

    assert_reset_fetch_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (sync_o && !irq_ack_o));

    assert_single_refetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_o && shape.single) |=> sync_o);

    assert_one_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sync_o, busy_o, irq_ack_o}) == 1);

    assert_no_ack_after_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |=> !irq_ack_o);

    assert_ack_then_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack_o |=> (sync_o && pc_inc_o));

    assert_mask_honoured_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack_o && !ack_nmi_o) |-> $past(irq_i && !irq_mask_i));
endmodule

// File: tb/nop_seq_core_bench.sv
`timescale 1ns/1ps
module nop_seq_core_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] data_i = 8'h00;
    logic       irq_i = 1'b0;
    logic       irq_mask_i = 1'b0;
    logic       nmi_i = 1'b0;
    logic       sync_o, pc_inc_o, busy_o, irq_ack_o, ack_nmi_o;

    always #5 clk = ~clk;

    nop_seq_core u_nop_seq_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_i     (data_i),
        .irq_i      (irq_i),
        .irq_mask_i (irq_mask_i),
        .nmi_i      (nmi_i),
        .sync_o     (sync_o),
        .pc_inc_o   (pc_inc_o),
        .busy_o     (busy_o),
        .irq_ack_o  (irq_ack_o),
        .ack_nmi_o  (ack_nmi_o)
    );

    typedef struct {
        bit sync, inc, busy, ack, anmi;
        int req;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 0;
    bit   irq_lvl = 0, mask_lvl = 0, nmi_lvl = 0;
    bit   nmi_pend = 0, nmi_prev_b = 0;

    // shape of each opcode, taken from the requirements
    function automatic void ref_shape(input logic [7:0] op, output int cyc, output int len);
        logic [3:0] lo, hi;
        lo = op[3:0];
        hi = op[7:4];
        if (lo == 4'h3 || lo == 4'hB) begin cyc = 1; len = 1; end
        else if (lo == 4'h2 && !hi[0] && hi != 4'hA) begin cyc = 2; len = 2; end
        else if (op == 8'h44) begin cyc = 3; len = 2; end
        else if (op == 8'h54 || op == 8'hD4 || op == 8'hF4) begin cyc = 4; len = 2; end
        else if (op == 8'h5C) begin cyc = 8; len = 3; end
        else if (op == 8'hDC || op == 8'hFC) begin cyc = 4; len = 3; end
        else begin cyc = 2; len = 1; end
    endfunction

    task automatic step(input logic [7:0] d, input bit s, input bit inc, input bit b,
                        input bit a, input bit an, input int req);
        exp_t e;
        @(negedge clk);
        data_i = d; irq_i = irq_lvl; irq_mask_i = mask_lvl; nmi_i = nmi_lvl;
        e.sync = s; e.inc = inc; e.busy = b; e.ack = a; e.anmi = an; e.req = req;
        q.push_back(e);
        if (a && an) nmi_pend = 0;
        if (nmi_lvl && !nmi_prev_b) nmi_pend = 1;
        nmi_prev_b = nmi_lvl;
    endtask

    task automatic instr(input logic [7:0] op, input int req);
        int  cyc, len;
        bit  take, sel;
        ref_shape(op, cyc, len);
        take = 0; sel = 0;
        step(op, 1, 1, 0, 0, 0, req);
        for (int c = 1; c < cyc; c++) begin
            if (c == cyc - 1) begin
                take = nmi_pend || (irq_lvl && !mask_lvl);
                sel  = nmi_pend;
            end
            step(8'h00, 0, (c < len), 1, 0, 0, req);
        end
        if (take) step(8'h00, 0, 0, 0, 1, sel, 9);
    endtask

    // monitor: compares every cycle against the queue
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if ({sync_o, pc_inc_o, busy_o, irq_ack_o, ack_nmi_o} !==
                    {e.sync, e.inc, e.busy, e.ack, e.anmi}) begin
                    fails++;
                    $display("FAIL R%0d sync/inc/busy/ack/nmi actual=%b%b%b%b%b expected=%b%b%b%b%b",
                             e.req, sync_o, pc_inc_o, busy_o, irq_ack_o, ack_nmi_o,
                             e.sync, e.inc, e.busy, e.ack, e.anmi);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: state during reset
        repeat (3) @(negedge clk);
        #2;
        checks++;
        if ({sync_o, busy_o, irq_ack_o} !== 3'b100) begin
            fails++;
            $display("FAIL R1 reset sync/busy/ack actual=%b expected=100", {sync_o, busy_o, irq_ack_o});
        end
        @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: first cycle after reset is a fetch (checked by first instr step)
        // R2: single-cycle no-ops
        instr(8'h03, 2); instr(8'hFB, 2); instr(8'h7B, 2);
        // R3
        instr(8'h02, 3); instr(8'hE2, 3); instr(8'h82, 3);
        // R4
        instr(8'h44, 4);
        // R5
        instr(8'h54, 5); instr(8'hD4, 5); instr(8'hF4, 5);
        // R6
        instr(8'h5C, 6); instr(8'hDC, 6); instr(8'hFC, 6);
        // R7: placeholders, including A2 next to the 2-byte column
        instr(8'hEA, 7); instr(8'hA2, 7); instr(8'h00, 7);

        // R8 / R9: maskable request taken at the end of a normal instruction
        irq_lvl = 1;
        instr(8'hEA, 9);
        irq_lvl = 0;
        instr(8'h44, 8);

        // R11: masked request is ignored, then taken once unmasked
        irq_lvl = 1; mask_lvl = 1;
        instr(8'hEA, 11); instr(8'h54, 11);
        mask_lvl = 0;
        instr(8'h02, 11);
        irq_lvl = 0;

        // R10: run of single-cycle no-ops fuses with the next instruction
        irq_lvl = 1;
        instr(8'h03, 10); instr(8'h0B, 10); instr(8'h13, 10); instr(8'hEA, 10);
        irq_lvl = 0;
        instr(8'h5C, 10);

        // R12: edge latched through a masked period and a single-cycle no-op
        mask_lvl = 1; irq_lvl = 1; nmi_lvl = 1;
        instr(8'h33, 12); instr(8'hEA, 12);
        // held level: no further acceptance
        instr(8'hEA, 12); instr(8'hDC, 12);
        nmi_lvl = 0;
        instr(8'hEA, 12);
        // R12: priority over unmasked request, then the maskable one follows
        mask_lvl = 0; nmi_lvl = 1;
        instr(8'hEA, 12);
        nmi_lvl = 0;
        instr(8'hEA, 12);
        irq_lvl = 0;
        instr(8'h5C, 6);
        // R9: long no-op with request accepted after its eighth cycle
        irq_lvl = 1;
        instr(8'h5C, 9);
        irq_lvl = 0;
        instr(8'hEA, 7);

        @(negedge clk);
        #5;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule